// File: doc/BRIEF.md
# Polarity-Adjusting Interrupt Latch Controller

This block sits between a set of peripheral interrupt request wires and a parent interrupt controller that only understands active-high level requests. Each request line is first brought into the local clock domain by a two-flop synchroniser. A per-line reverse-polarity bit then optionally inverts it, so active-low levels and falling edges are seen as active-high levels and rising edges. Lines built in level mode pass the corrected value straight on. Lines built in edge mode capture each rising corrected edge in a latch that holds until software writes a one to the line's end-of-interrupt bit. A per-line mask bit gates every output toward the parent.

Software reaches the controls through a 16-bit register port with a byte address. Three register groups exist: mask at 0x00, reverse polarity at 0x10 and end-of-interrupt at 0x20. Line n lives at bit (n mod 16) of the word at group offset + (n div 16) × 4. Each edge-mode line has a two-state machine with the states `LN_IDLE` (nothing latched) and `LN_HELD` (request latched). The transition *capture* (`LN_IDLE` → `LN_HELD`) happens on a rising corrected edge. The transition *release* (`LN_HELD` → `LN_HELD` is left for `LN_IDLE`) happens on an end-of-interrupt pulse with no edge in the same cycle. Every other case stays in the current state (*hold*). A build parameter `HAS_EOI` can remove end-of-interrupt support, and a parameter vector `EDGE_LINES` picks edge or level mode for each line.

Top module: `pol_irq_latch`

## Requirements
- R1: After reset every mask bit is 1 (each mask word reads 0xFFFF), every polarity bit is 0, every latch is clear and all outputs are 0.
- R2: Registers decode only at aligned addresses (address bits [1:0] = 0, bits [7:6] = 0). Bits [5:4] select the group (0 = mask, 1 = polarity, 2 = end-of-interrupt) and bits [3:2] select the word of 16 lines. Any other address reads 0 and writes to it change nothing.
- R3: A mask bit of 1 forces the line's output to 0, and a mask bit of 0 lets the line's active state through.
- R4: A polarity bit of 1 inverts the synchronised input before level and edge handling, and a polarity bit of 0 passes it unchanged. A polarity change that makes the corrected value rise counts as a rising edge.
- R5: A level-mode line's unmasked output equals its polarity-corrected input, two clock edges after the raw input changes. With the default `EDGE_LINES`, lines 32 to 63 are level mode.
- R6: An edge-mode line latches each rising corrected edge, and the output stays 1 after the input falls. With the default `EDGE_LINES`, lines 0 to 31 are edge mode.
- R7: Writing 1 to a line's end-of-interrupt bit clears its latch. End-of-interrupt bits written 0 have no effect, and end-of-interrupt words always read 0.
- R8: If a new rising edge and an end-of-interrupt for the same line happen in the same cycle, the latch stays set.
- R9: With `HAS_EOI` = 0, end-of-interrupt writes have no effect and a latch, once set, stays set.
- R10: Mask and polarity words read back exactly what was last written. A write to one word leaves every other word unchanged.
- R11: Masking does not stop latching. An edge that arrives while the line is masked appears at the output once the line is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_in | input | NUM_LINES | Raw request inputs from peripherals |
| irq_out | output | NUM_LINES | Active-high level requests toward the parent |

## Verification
The embedded assertions check the following on every cycle: a masked line never drives its output, unaligned or unused addresses read zero, and end-of-interrupt words read zero. For edge-mode lines they also check that every rising corrected edge leads to the held state, that a held line leaves it only through an end-of-interrupt pulse without a collision, and that a held line never leaves it when `HAS_EOI` is 0. Other behaviour can only be shown by the bench's scenarios. This covers the two-edge synchroniser latency, polarity inversion acting on both level and edge lines, latching while masked followed by a later unmask, the exact collision cycle, and mask and polarity readback. The bench checks these against a bench-side model while driving a seeded random mix of input changes and register writes into two instances, one with end-of-interrupt support and one without.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 8;

    // register group selected by address bits [5:4]
    typedef enum logic [1:0] {
        GRP_MASK = 2'd0,
        GRP_POL  = 2'd1,
        GRP_EOI  = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    // per-line latch state for edge-mode lines
    typedef enum logic [0:0] {
        LN_IDLE = 1'b0,
        LN_HELD = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqlat_regs.sv
module irqlat_regs
    import irqlat_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] pol_o,
    output logic [NUM_LINES-1:0] eoi_o
);

    localparam int NBANK = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int PADW  = NBANK * REG_W;

    logic        addr_ok;
    reg_grp_e    grp;
    logic [1:0]  bank;
    logic [PADW-1:0] mask_q;
    logic [PADW-1:0] pol_q;

    // aligned, inside the three groups, and inside the populated words
    assign addr_ok = (addr[1:0] == 2'b00) && (addr[7:6] == 2'b00)
                     && (addr[5:4] != 2'b11) && (int'(addr[3:2]) < NBANK);
    assign grp     = reg_grp_e'(addr[5:4]);
    assign bank    = addr[3:2];

    generate
        for (genvar i = 0; i < PADW; i++) begin : g_bit
            localparam int BK = i / REG_W;
            localparam int BT = i % REG_W;
            if (i < NUM_LINES) begin : g_live
                logic hit;
                logic m_bit;
                logic p_bit;
                assign hit = wr_en && addr_ok && (int'(bank) == BK);
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        m_bit <= 1'b1;
                        p_bit <= 1'b0;
                    end else if (hit) begin
                        if (grp == GRP_MASK) m_bit <= wdata[BT];
                        if (grp == GRP_POL)  p_bit <= wdata[BT];
                    end
                end
                assign mask_q[i] = m_bit;
                assign pol_q[i]  = p_bit;
                assign eoi_o[i]  = hit && (grp == GRP_EOI) && wdata[BT];
            end else begin : g_pad
                assign mask_q[i] = 1'b0;
                assign pol_q[i]  = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            for (int b = 0; b < NBANK; b++) begin
                if (int'(bank) == b) begin
                    unique case (grp)
                        GRP_MASK: rdata = mask_q[b*REG_W +: REG_W];
                        GRP_POL:  rdata = pol_q[b*REG_W +: REG_W];
                        default:  rdata = '0;
                    endcase
                end
            end
        end
    end

    assign mask_o = mask_q[NUM_LINES-1:0];
    assign pol_o  = pol_q[NUM_LINES-1:0];

    // R7
    eoi_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ok && grp == GRP_EOI) |-> (rdata == '0));

    // R2
    bad_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ok) |-> (rdata == '0));

endmodule

// File: rtl/irqlat_line.sv
module irqlat_line
    import irqlat_pkg::*;
#(
    parameter bit EDGE_MODE = 1'b1,
    parameter bit HAS_EOI   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic mask_i,
    input  logic eoi_i,
    output logic irq_o
);

    logic s1_q;
    logic s2_q;
    logic corr;
    logic active;

    // two-flop synchroniser on the raw request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
        end
    end

    assign corr = s2_q ^ pol_i;

    generate
        if (EDGE_MODE) begin : g_edge
            line_state_e state_q;
            line_state_e state_d;
            logic        prev_q;
            logic        rise;
            logic        eoi_eff;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= corr;
            end

            assign rise    = corr & ~prev_q;
            assign eoi_eff = HAS_EOI ? eoi_i : 1'b0;

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= LN_IDLE;
                else        state_q <= state_d;
            end

            // next state: capture, release, hold
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    LN_IDLE: if (rise)             state_d = LN_HELD;
                    LN_HELD: if (eoi_eff && !rise) state_d = LN_IDLE;
                    default:                       state_d = LN_IDLE;
                endcase
            end

            // outputs
            always_comb begin
                active = (state_q == LN_HELD);
            end

            // R6
            edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise |=> (state_q == LN_HELD));

            // R8
            collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == LN_HELD && eoi_i && rise) |=> (state_q == LN_HELD));

            // R7
            held_until_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == LN_HELD && !eoi_i) |=> (state_q == LN_HELD));

            if (!HAS_EOI) begin : g_no_eoi_chk
                // R9
                no_eoi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (state_q == LN_HELD) |=> (state_q == LN_HELD));
            end
        end else begin : g_level
            logic unused_eoi;
            assign unused_eoi = eoi_i;
            always_comb begin
                active = corr;
            end
        end
    endgenerate

    assign irq_o = active & ~mask_i;

endmodule

// File: rtl/pol_irq_latch.sv
module pol_irq_latch
    import irqlat_pkg::*;
#(
    parameter int                   NUM_LINES  = 64,
    parameter bit                   HAS_EOI    = 1'b1,
    parameter logic [NUM_LINES-1:0] EDGE_LINES = 64'h0000_0000_FFFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] mask_v;
    logic [NUM_LINES-1:0] pol_v;
    logic [NUM_LINES-1:0] eoi_v;

    irqlat_regs #(
        .NUM_LINES (NUM_LINES)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .mask_o (mask_v),
        .pol_o  (pol_v),
        .eoi_o  (eoi_v)
    );

    generate
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            irqlat_line #(
                .EDGE_MODE (EDGE_LINES[n]),
                .HAS_EOI   (HAS_EOI)
            ) u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (irq_in[n]),
                .pol_i  (pol_v[n]),
                .mask_i (mask_v[n]),
                .eoi_i  (eoi_v[n]),
                .irq_o  (irq_out[n])
            );
        end
    endgenerate

    // R3
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & mask_v) == '0));

endmodule

// File: tb/pol_irq_latch_bench.sv
`timescale 1ns/1ps
module pol_irq_latch_bench;

    localparam logic [63:0] EDGE_M = 64'h0000_0000_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rdata_a;
    logic [15:0] rdata_b;
    logic [63:0] irq_in = '0;
    logic [63:0] out_a;
    logic [63:0] out_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_mask, m_pol, m_in, m_lat_a, m_lat_b;

    always #2 clk = ~clk;

    pol_irq_latch #(.NUM_LINES(64), .HAS_EOI(1'b1), .EDGE_LINES(EDGE_M)) u_pol_irq_latch (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_in(irq_in), .irq_out(out_a));

    pol_irq_latch #(.NUM_LINES(64), .HAS_EOI(1'b0), .EDGE_LINES(EDGE_M)) u_pol_irq_latch_noeoi (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq_in(irq_in), .irq_out(out_b));

    function automatic logic [63:0] exp_out(input logic [63:0] lat);
        logic [63:0] corr;
        corr = m_in ^ m_pol;
        return ((EDGE_M & lat) | (~EDGE_M & corr)) & ~m_mask;
    endfunction

    task automatic note_corr(input logic [63:0] old_c, input logic [63:0] new_c);
        logic [63:0] rise;
        rise = new_c & ~old_c & EDGE_M;
        m_lat_a |= rise;
        m_lat_b |= rise;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " out"}, out_a, exp_out(m_lat_a));
        check({req, " out_noeoi"}, out_b, exp_out(m_lat_b));
    endtask

    task automatic set_in(input logic [63:0] v);
        logic [63:0] old_c;
        old_c = m_in ^ m_pol;
        m_in = v;
        irq_in = v;
        note_corr(old_c, m_in ^ m_pol);
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        logic [63:0] old_c;
        int bk;
        reg_addr = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        bk = int'(a[3:2]);
        if (a[1:0] == 2'b00 && a[7:6] == 2'b00) begin
            case (a[5:4])
                2'd0: m_mask[bk*16 +: 16] = d;
                2'd1: begin
                    old_c = m_in ^ m_pol;
                    m_pol[bk*16 +: 16] = d;
                    note_corr(old_c, m_in ^ m_pol);
                end
                2'd2: m_lat_a[bk*16 +: 16] = m_lat_a[bk*16 +: 16] & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = rdata_a;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] rv;
        m_mask = '1; m_pol = '0; m_in = '0; m_lat_a = '0; m_lat_b = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out", out_a, 64'h0);
        check("R1 out_noeoi", out_b, 64'h0);
        for (int b = 0; b < 4; b++) begin
            reg_read(8'(b*4), rv);
            check("R1 mask word", 64'(rv), 64'hFFFF);
            reg_read(8'(8'h10 + b*4), rv);
            check("R1 pol word", 64'(rv), 64'h0);
        end

        // R2: unused and unaligned addresses
        reg_read(8'h30, rv);
        check("R2 read 0x30", 64'(rv), 64'h0);
        reg_read(8'h01, rv);
        check("R2 read 0x01", 64'(rv), 64'h0);
        @(negedge clk);
        reg_write(8'h01, 16'h0000);
        reg_write(8'h41, 16'h0000);
        reg_read(8'h00, rv);
        check("R2 bad write ignored", 64'(rv), 64'hFFFF);

        // R7: EOI words read zero
        reg_read(8'h20, rv);
        check("R7 eoi reads zero", 64'(rv), 64'h0);
        @(negedge clk);

        // unmask everything
        for (int b = 0; b < 4; b++) reg_write(8'(b*4), 16'h0000);
        settle();
        check_outs("R3 unmasked idle");

        // R5: level line 40, two-edge latency
        set_in(m_in | (64'h1 << 40));
        @(negedge clk);
        check("R5 level after 1 edge", 64'(out_a[40]), 64'h0);
        @(negedge clk);
        check("R5 level after 2 edges", 64'(out_a[40]), 64'h1);
        set_in(m_in & ~(64'h1 << 40));
        settle();
        check_outs("R5 level drops");

        // R6: edge line 5 stays latched after input falls
        set_in(m_in | (64'h1 << 5));
        settle();
        set_in(m_in & ~(64'h1 << 5));
        settle();
        check("R6 latched after fall", 64'(out_a[5]), 64'h1);
        check_outs("R6 edge latch");

        // R4: polarity on edge line 6 and level line 33
        reg_write(8'h10, 16'h0040);
        reg_write(8'h18, 16'h0002);
        settle();
        check("R4 pol edge line", 64'(out_a[6]), 64'h1);
        check("R4 pol level line", 64'(out_a[33]), 64'h1);
        check_outs("R4 polarity");

        // R7 / R9: EOI clears line 5 only where supported
        reg_write(8'h20, 16'h0000);
        settle();
        check_outs("R7 eoi zero no effect");
        reg_write(8'h20, 16'h0020);
        settle();
        check("R7 eoi clears", 64'(out_a[5]), 64'h0);
        check("R9 no eoi keeps", 64'(out_b[5]), 64'h1);
        check_outs("R7 R9 eoi");

        // R11: latch while masked on line 7
        reg_write(8'h00, 16'h0080);
        set_in(m_in | (64'h1 << 7));
        settle();
        set_in(m_in & ~(64'h1 << 7));
        settle();
        check("R11 masked out", 64'(out_a[7]), 64'h0);
        reg_write(8'h00, 16'h0000);
        settle();
        check("R11 after unmask", 64'(out_a[7]), 64'h1);

        // R8: collision on line 3 (latched first)
        set_in(m_in | (64'h1 << 3));
        settle();
        set_in(m_in & ~(64'h1 << 3));
        settle();
        irq_in[3] = 1'b1;
        m_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 8'h20; reg_wdata = 16'h0008; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        settle();
        check("R8 collision keeps", 64'(out_a[3]), 64'h1);
        check_outs("R8 collision");

        // R10: readback and isolation
        reg_write(8'h04, 16'hA5A5);
        reg_write(8'h1C, 16'h1234);
        reg_read(8'h04, rv);
        check("R10 mask readback", 64'(rv), 64'hA5A5);
        reg_read(8'h1C, rv);
        check("R10 pol readback", 64'(rv), 64'h1234);
        reg_read(8'h00, rv);
        check("R10 other word", 64'(rv), 64'(m_mask[15:0]));
        @(negedge clk);
        settle();
        check_outs("R10 after writes");

        // random mix
        for (int s = 0; s < 300; s++) begin
            int op;
            int bk;
            logic [15:0] d;
            op = int'($urandom % 5);
            bk = int'($urandom % 4);
            d = 16'($urandom);
            case (op)
                0, 1: set_in({$urandom, $urandom});
                2: reg_write(8'(bk*4), d & 16'($urandom));
                3: reg_write(8'(8'h10 + bk*4), d);
                default: reg_write(8'(8'h20 + bk*4), d);
            endcase
            settle();
            check_outs("R3 R4 R5 R6 R7 R9 random");
            if (s % 25 == 0) begin
                reg_read(8'(bk*4), rv);
                check("R10 random mask readback", 64'(rv), 64'(m_mask[bk*16 +: 16]));
                reg_read(8'(8'h10 + bk*4), rv);
                check("R10 random pol readback", 64'(rv), 64'(m_pol[bk*16 +: 16]));
                @(negedge clk);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule